// File: doc/BRIEF.md
# Serial Converter Channel Scan Master

This block is the host side of a link to an eight-input, 10-bit serial sampling converter. It divides the system clock down to the serial clock, drives the active-low select and the serial command line, and shifts in the converter's reply. It walks the channels allowed by an enable mask in ascending order and wraps around. In every 16-clock frame it sends the address of the next channel and collects one 10-bit result.

The converter always answers with the sample for the address sent one frame earlier. After a reset it answers with channel 0. The master therefore keeps the address of the previous frame as the pending channel and tags each result with it. It throws away the first reply after reset, which it did not request. Results leave on a valid/ready port together with the channel tag and a flag that reports a non-zero padding bit. In burst mode the select line is released after every frame. In continuous mode it stays low across frames for as long as scanning goes on and the output has room.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The serial clock sits high whenever select is high. Inside a frame each low phase lasts exactly DIV_HALF system cycles and each high phase lasts at least DIV_HALF cycles.
- R2: Every interval with select low holds a non-zero multiple of 16 rising serial-clock edges.
- R3: On the first 8 rising edges of a frame the command line carries a byte, MSB first, whose bits 5:3 are the address of the channel to be sampled next. Every other command bit in the frame is zero. The command line changes only when the serial clock falls or when select rises.
- R4: The reply is sampled on each rising edge. Reply slots 5 to 14 (slot 1 on the first edge) form the result, MSB first.
- R5: Each result carries the channel addressed in the frame before it. The reply of the first frame after reset is never presented.
- R6: Frames address the enabled channels in ascending order and wrap from 7 to 0, skipping disabled channels. The first address after reset is the lowest enabled channel. No frame starts while the mask is zero or scanning is off.
- R7: In continuous mode (cont_mode_i=1) select stays low from frame to frame. The next frame's first falling edge comes half a serial period after the 16th rising edge.
- R8: In burst mode select goes high after each frame. Between two frames select stays high for at least 2*DIV_HALF system cycles.
- R9: A presented result keeps valid high and its data, tag and flag stable until ready is seen. If the consumer stalls, the master raises select and waits before the next frame, and no result is lost.
- R10: res_pad_err_o is high with a result exactly when one of reply slots 1-4, 15 or 16 of that frame was read as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Allow new frames to start |
| cont_mode_i | input | 1 | 1: continuous frames, 0: burst frames |
| chan_en_i | input | 8 | Enable mask, bit n allows channel n |
| ser_clk_o | output | 1 | Serial clock to the converter |
| ser_cs_no | output | 1 | Converter select, active low |
| ser_din_o | output | 1 | Command bit to the converter |
| ser_dout_i | input | 1 | Reply bit from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | 10 | Conversion result |
| res_chan_o | output | 3 | Channel the result belongs to |
| res_pad_err_o | output | 1 | A padding slot was read as one |

## Verification
A behavioural converter model in the bench latches the commanded address and, one frame later, replies with a distinct per-channel code; the codes include all-zeros, all-ones and alternating patterns. A correct tag is therefore visible in the data as well. A sparse mask in burst mode separates a correct one-frame pipeline from one that tags with the current address or lets the unrequested first reply through. A mask with channel 0 in continuous mode tests the wrap and shows that select stays low. A full mask with a stalled consumer shows the wait-with-select-high path and that the sequence resumes without a gap. A set bit in slot 16 raises the flag without changing the data. A zero mask and scanning switched off both keep the link quiet.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned CH_W      = 3;
  localparam int unsigned CH_N      = 1 << CH_W;
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned CTRL_LEN  = 8;
  localparam int unsigned CH_LSB    = 3;   // address position inside the command byte
  localparam int unsigned RES_W     = 10;
  localparam int unsigned RES_LSB   = 2;   // two trailing pad slots

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } scan_st_e;

  function automatic logic [FRAME_LEN-1:0] ctrl_word(input logic [CH_W-1:0] ch);
    logic [FRAME_LEN-1:0] w;
    w = '0;
    w[FRAME_LEN-CTRL_LEN+CH_LSB +: CH_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
  parameter int unsigned DIV_HALF = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int unsigned W = 3,
  parameter int unsigned N = 1 << W
) (
  input  logic [N-1:0] mask_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] next_o,
  output logic         any_o
);
  logic [W-1:0] idx;
  logic         found;

  assign any_o = |mask_i;

  // round robin: first enabled channel strictly after last_i, wrapping
  always_comb begin
    next_o = last_i;
    found  = 1'b0;
    idx    = '0;
    for (int k = 1; k <= int'(N); k++) begin
      idx = last_i + W'(k);
      if (!found && mask_i[idx]) begin
        next_o = idx;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_frame_io.sv
module adc_frame_io
  import adc_scan_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_i,
  input  logic [FRAME_LEN-1:0] ld_word_i,
  input  logic                 shift_i,
  input  logic                 cap_i,
  input  logic                 dout_i,
  output logic                 tx_msb_o,
  output logic [RES_W-1:0]     res_o,
  output logic                 pad_err_o
);
  localparam logic [FRAME_LEN-1:0] RES_MASK = FRAME_LEN'(((1 << RES_W) - 1) << RES_LSB);
  localparam logic [FRAME_LEN-1:0] PAD_MASK = ~RES_MASK;

  logic [FRAME_LEN-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (ld_i)         tx_q <= shift_i ? {ld_word_i[FRAME_LEN-2:0], 1'b0} : ld_word_i;
      else if (shift_i) tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
      if (cap_i)        rx_q <= {rx_q[FRAME_LEN-2:0], dout_i};
    end
  end

  assign tx_msb_o  = tx_q[FRAME_LEN-1];
  assign res_o     = rx_q[RES_LSB +: RES_W];
  assign pad_err_o = |(rx_q & PAD_MASK);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned DIV_HALF = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic             cont_mode_i,
  input  logic [CH_N-1:0]  chan_en_i,
  output logic             ser_clk_o,
  output logic             ser_cs_no,
  output logic             ser_din_o,
  input  logic             ser_dout_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [RES_W-1:0] res_data_o,
  output logic [CH_W-1:0]  res_chan_o,
  output logic             res_pad_err_o
);
  localparam int unsigned        BIT_W    = $clog2(FRAME_LEN);
  localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(FRAME_LEN - 1);

  scan_st_e             st_q;
  logic                 sclk_q, cs_n_q, din_q, gap_q;
  logic [BIT_W-1:0]     bit_q;
  logic [CH_W-1:0]      last_q, sent_q, pend_q, hold_ch_q;
  logic                 pend_keep_q;
  logic                 val_q, pad_q;
  logic [RES_W-1:0]     data_q;
  logic [CH_W-1:0]      chan_q;

  logic                 tick, pick_any, tx_msb, rx_pad;
  logic [CH_W-1:0]      pick_ch;
  logic [RES_W-1:0]     rx_res;
  logic [FRAME_LEN-1:0] word;
  logic                 start_idle, frame_end, stall, restart;
  logic                 tx_ld, tx_shift, rx_cap, out_direct, out_hold;

  adc_sclk_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  adc_chan_pick #(.W(CH_W), .N(CH_N)) u_pick (
    .mask_i (chan_en_i),
    .last_i (last_q),
    .next_o (pick_ch),
    .any_o  (pick_any)
  );

  assign word = ctrl_word(pick_ch);

  adc_frame_io u_io (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (tx_ld),
    .ld_word_i (word),
    .shift_i   (tx_shift),
    .cap_i     (rx_cap),
    .dout_i    (ser_dout_i),
    .tx_msb_o  (tx_msb),
    .res_o     (rx_res),
    .pad_err_o (rx_pad)
  );

  always_comb begin
    start_idle = tick && (st_q == ST_IDLE) && scan_en_i && pick_any;
    frame_end  = tick && (st_q == ST_HIGH) && (bit_q == LAST_BIT);
    stall      = pend_keep_q && val_q;
    restart    = frame_end && !stall && cont_mode_i && scan_en_i && pick_any;
    tx_ld      = start_idle || restart;
    tx_shift   = (tick && (st_q == ST_LEAD))
              || (tick && (st_q == ST_HIGH) && (bit_q != LAST_BIT))
              || restart;
    rx_cap     = tick && (st_q == ST_LOW);
    out_direct = frame_end && pend_keep_q && !val_q;
    out_hold   = tick && (st_q == ST_HOLD) && !val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sclk_q      <= 1'b1;
      cs_n_q      <= 1'b1;
      din_q       <= 1'b0;
      gap_q       <= 1'b0;
      bit_q       <= '0;
      last_q      <= CH_W'(CH_N - 1);
      sent_q      <= '0;
      pend_q      <= '0;   // converter answers channel 0 first
      pend_keep_q <= 1'b0; // first reply is unrequested
      hold_ch_q   <= '0;
      val_q       <= 1'b0;
      data_q      <= '0;
      chan_q      <= '0;
      pad_q       <= 1'b0;
    end else begin
      if (val_q && res_ready_i) val_q <= 1'b0;
      if (out_direct) begin
        val_q  <= 1'b1;
        data_q <= rx_res;
        chan_q <= pend_q;
        pad_q  <= rx_pad;
      end
      if (out_hold) begin
        val_q  <= 1'b1;
        data_q <= rx_res;
        chan_q <= hold_ch_q;
        pad_q  <= rx_pad;
      end
      if (tx_ld) begin
        sent_q <= pick_ch;
        last_q <= pick_ch;
      end
      if (tx_shift) din_q <= restart ? word[FRAME_LEN-1] : tx_msb;

      if (tick) begin
        unique case (st_q)
          ST_IDLE: if (start_idle) begin
            cs_n_q <= 1'b0;
            st_q   <= ST_LEAD;
          end
          ST_LEAD: begin
            sclk_q <= 1'b0;
            bit_q  <= '0;
            st_q   <= ST_LOW;
          end
          ST_LOW: begin
            sclk_q <= 1'b1;
            st_q   <= ST_HIGH;
          end
          ST_HIGH: begin
            if (bit_q != LAST_BIT) begin
              sclk_q <= 1'b0;
              bit_q  <= bit_q + BIT_W'(1);
              st_q   <= ST_LOW;
            end else begin
              pend_q      <= sent_q;
              pend_keep_q <= 1'b1;
              if (stall) begin
                hold_ch_q <= pend_q;
                cs_n_q    <= 1'b1;
                din_q     <= 1'b0;
                st_q      <= ST_HOLD;
              end else if (restart) begin
                sclk_q <= 1'b0;
                bit_q  <= '0;
                st_q   <= ST_LOW;
              end else begin
                cs_n_q <= 1'b1;
                din_q  <= 1'b0;
                gap_q  <= 1'b0;
                st_q   <= ST_GAP;
              end
            end
          end
          ST_HOLD: if (!val_q) begin
            gap_q <= 1'b0;
            st_q  <= ST_GAP;
          end
          ST_GAP: begin
            gap_q <= 1'b1;
            if (gap_q) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ser_clk_o     = sclk_q;
  assign ser_cs_no     = cs_n_q;
  assign ser_din_o     = din_q;
  assign res_valid_o   = val_q;
  assign res_data_o    = data_q;
  assign res_chan_o    = chan_q;
  assign res_pad_err_o = pad_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
  import adc_scan_pkg::*;
#(
  parameter int unsigned DIV_HALF = 50
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_clk_o,
  input logic             ser_cs_no,
  input logic             ser_din_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [RES_W-1:0] res_data_o,
  input logic [CH_W-1:0]  res_chan_o,
  input logic             res_pad_err_o
);
  logic        p_sclk, p_cs, p_din, any_rise, seen_frame;
  logic [15:0] lvl_q, hi_q;
  logic [3:0]  rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_sclk     <= 1'b1;
      p_cs       <= 1'b1;
      p_din      <= 1'b0;
      lvl_q      <= '0;
      hi_q       <= '0;
      rise_q     <= '0;
      any_rise   <= 1'b0;
      seen_frame <= 1'b0;
    end else begin
      p_sclk <= ser_clk_o;
      p_cs   <= ser_cs_no;
      p_din  <= ser_din_o;
      lvl_q  <= (ser_clk_o != p_sclk) ? 16'd1 : ((lvl_q == 16'hFFFF) ? lvl_q : lvl_q + 16'd1);
      hi_q   <= !ser_cs_no ? '0 : ((hi_q == 16'hFFFF) ? hi_q : hi_q + 16'd1);
      if (ser_cs_no) begin
        rise_q   <= '0;
        any_rise <= 1'b0;
      end else if (ser_clk_o && !p_sclk) begin
        rise_q   <= rise_q + 4'd1;
        any_rise <= 1'b1;
      end
      if (ser_cs_no && !p_cs) seen_frame <= 1'b1;
    end
  end

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_cs_no |-> ser_clk_o);

  a_r1_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && !p_sclk) |-> (lvl_q == 16'(DIV_HALF)));

  a_r2_whole_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_cs_no && !p_cs) |-> (any_rise && rise_q == 4'd0));

  a_r3_din_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_din_o != p_din) |-> ((!ser_clk_o && p_sclk) || (ser_cs_no && !p_cs)));

  a_r8_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_cs_no && p_cs && seen_frame) |-> (hi_q >= 16'(2 * DIV_HALF)));

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)
      && $stable(res_chan_o) && $stable(res_pad_err_o)));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ser_clk_o     (ser_clk_o),
  .ser_cs_no     (ser_cs_no),
  .ser_din_o     (ser_din_o),
  .res_valid_o   (res_valid_o),
  .res_ready_i   (res_ready_i),
  .res_data_o    (res_data_o),
  .res_chan_o    (res_chan_o),
  .res_pad_err_o (res_pad_err_o)
);

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0, cont = 1'b0, ready = 1'b0, dout = 1'b0;
  logic [7:0] mask = 8'h00;
  logic       sclk, cs_n, din, valid, pad;
  logic [9:0] data;
  logic [2:0] chan;

  always #2 clk = ~clk;

  adc_scan_ctrl #(.DIV_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .cont_mode_i(cont),
    .chan_en_i(mask), .ser_clk_o(sclk), .ser_cs_no(cs_n), .ser_din_o(din),
    .ser_dout_i(dout), .res_valid_o(valid), .res_ready_i(ready),
    .res_data_o(data), .res_chan_o(chan), .res_pad_err_o(pad)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [9:0] val [8];
  int         pad_slot = 0;
  logic [2:0] reg_addr = 3'd0, conv_ch = 3'd0;
  logic [7:0] csh = 8'h00;
  int         fcnt = 0, rcnt = 0, din_bad = 0;

  function automatic logic slot_bit(int s, logic [9:0] v);
    if (s >= 5 && s <= 14) return v[14-s];
    return (s == pad_slot);
  endfunction

  always @(negedge cs_n) begin fcnt = 0; rcnt = 0; end
  always @(posedge cs_n) dout = 1'b0;

  always @(negedge sclk) if (!cs_n) begin
    int s;
    fcnt++;
    s = ((fcnt - 1) % 16) + 1;
    if (s == 1) conv_ch = reg_addr;
    dout = slot_bit(s, val[conv_ch]);
  end

  always @(posedge sclk) if (!cs_n) begin
    int p;
    rcnt++;
    p = (rcnt - 1) % 16;
    if (p < 8) begin
      csh = {csh[6:0], din};
      if (p == 7) reg_addr = csh[5:3];
      if (din && !(p >= 2 && p <= 4)) din_bad++;
    end else if (din) din_bad++;
  end

  // wire monitor
  logic p_cs = 1'b1, p_sclk = 1'b1, p_din = 1'b0;
  int   rises = 0, last_len = 0, hi_len = 0, low_len = 0, cs_falls = 0;
  int   frame_bad = 0, gap_bad = 0, low_bad = 0, idle_bad = 0, edge_bad = 0;
  bit   seen = 0;

  always @(negedge clk) begin
    if (!rst_n) seen = 0;
    else begin
      if (cs_n && !sclk) idle_bad++;
      if (sclk && !p_sclk && low_len != HALF) low_bad++;
      low_len = sclk ? 0 : low_len + 1;
      if (!cs_n && sclk && !p_sclk) rises++;
      if (cs_n && !p_cs) begin
        if (rises == 0 || (rises % 16) != 0) frame_bad++;
        last_len = rises; rises = 0; seen = 1;
      end
      if (!cs_n && p_cs) begin
        cs_falls++;
        if (seen && hi_len < 2 * HALF) gap_bad++;
      end
      hi_len = cs_n ? hi_len + 1 : 0;
      if (din !== p_din && !(!sclk && p_sclk) && !(cs_n && !p_cs)) edge_bad++;
    end
    p_cs = cs_n; p_sclk = sclk; p_din = din;
  end

  // expected scan order
  logic [2:0] exp_last = 3'd7;

  function automatic logic [2:0] nxt(logic [7:0] m, logic [2:0] l);
    for (int k = 1; k <= 8; k++) if (m[3'(l + 3'(k))]) return 3'(l + 3'(k));
    return l;
  endfunction

  task automatic take_one(string req);
    int t = 0;
    logic [2:0] c;
    while (!valid && t < 5000) begin @(negedge clk); t++; end
    if (!valid) begin
      chk({req, " result timeout"}, 0, 1);
      return;
    end
    c = nxt(mask, exp_last);
    chk({req, " tag"}, 32'(chan), 32'(c));
    chk({req, " data"}, 32'(data), 32'(val[c]));
    chk({req, " R10 pad flag"}, 32'(pad), 32'(pad_slot != 0));
    exp_last = c;
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic stop_drain(string req);
    scan_en = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (valid) take_one(req);
    end
  endtask

  task automatic restart(logic [7:0] m, logic c);
    rst_n = 1'b0;
    mask = m; cont = c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_last = 3'd7;
    scan_en = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 reset select", 32'(cs_n), 1);
    chk("R1 reset clock", 32'(sclk), 1);
    chk("R9 reset valid", 32'(valid), 0);
    chk("R3 reset command", 32'(din), 0);
  endtask

  task automatic t_burst;
    int f0;
    restart(8'hA6, 1'b0);
    f0 = cs_falls;
    for (int i = 0; i < 6; i++) take_one("R5 R6 R4 burst");
    chk("R8 one frame per select", 32'(last_len), 16);
    chk("R8 select released per frame", 32'(cs_falls - f0 >= 7), 1);
    stop_drain("R5 burst drain");
  endtask

  task automatic t_cont;
    int f0;
    restart(8'h19, 1'b1);
    f0 = cs_falls;
    for (int i = 0; i < 7; i++) take_one("R6 R7 continuous");
    chk("R7 single select fall", 32'(cs_falls - f0), 1);
    chk("R7 select still low", 32'(cs_n), 0);
    stop_drain("R7 drain");
  endtask

  task automatic t_stall;
    logic [9:0] d0;
    logic [2:0] c0;
    int t = 0;
    restart(8'hFF, 1'b1);
    for (int i = 0; i < 2; i++) take_one("R9 before stall");
    while (!valid && t < 5000) begin @(negedge clk); t++; end
    d0 = data; c0 = chan;
    repeat (600) @(negedge clk);
    chk("R9 valid held", 32'(valid), 1);
    chk("R9 data held", 32'(data), 32'(d0));
    chk("R9 tag held", 32'(chan), 32'(c0));
    chk("R9 select high while stalled", 32'(cs_n), 1);
    for (int i = 0; i < 9; i++) take_one("R9 after stall");
    stop_drain("R9 drain");
  endtask

  task automatic t_pad;
    pad_slot = 16;
    restart(8'h04, 1'b0);
    for (int i = 0; i < 3; i++) take_one("R10 trailing pad");
    stop_drain("R10 drain");
    pad_slot = 1;
    restart(8'h81, 1'b1);
    for (int i = 0; i < 3; i++) take_one("R10 leading pad");
    stop_drain("R10 drain");
    pad_slot = 0;
  endtask

  task automatic t_idle;
    int f0;
    restart(8'h00, 1'b1);
    f0 = cs_falls;
    repeat (800) @(negedge clk);
    chk("R6 zero mask no frame", 32'(cs_falls - f0), 0);
    mask = 8'hFF; scan_en = 1'b0;
    repeat (800) @(negedge clk);
    chk("R6 scan off no frame", 32'(cs_falls - f0), 0);
    chk("R9 nothing presented", 32'(valid), 0);
  endtask

  task automatic t_wire;
    chk("R1 clock high while idle", 32'(idle_bad), 0);
    chk("R1 low phase width", 32'(low_bad), 0);
    chk("R2 whole frames", 32'(frame_bad), 0);
    chk("R3 command bits", 32'(din_bad), 0);
    chk("R3 command edge", 32'(edge_bad), 0);
    chk("R8 select gap", 32'(gap_bad), 0);
  endtask

  initial begin
    val[0] = 10'h155; val[1] = 10'h3FF; val[2] = 10'h000; val[3] = 10'h2AA;
    val[4] = 10'h001; val[5] = 10'h200; val[6] = 10'h0F0; val[7] = 10'h30C;
    t_reset();
    rst_n = 1'b1;
    t_burst();
    t_cont();
    t_stall();
    t_pad();
    t_idle();
    t_wire();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule